// File: doc/BRIEF.md
# CAN Bit Stuffer and Destuffer

This block sits between the frame logic of a CAN controller and the bit-timing logic. On transmit, the frame logic offers one bit per bit time through a valid/ready handshake. After five equal bits the block inserts one bit of the opposite value and holds off the frame logic for that bit time. On receive, the block drops the bit that follows five equal bits. If that bit has the same value as the run, the block raises a stuff error instead. Six equal bits in a row is also the shape of an active error flag, so the same detector recognises an error flag sent by another node.

Separate region inputs on each path mark where stuffing applies. Outside a region, bits pass through unchanged and the run count is cleared. A flag generator can take over the transmit line and send a row of dominant bits with no stuffing. It starts either on an explicit request or, optionally, on every receive stuff error. All activity advances on a single-cycle bit strobe.

Top module: `can_stuff_unit`

## Requirements
- R1: After reset, `tx_bit` is 1 (recessive), `tx_ready` is 1, and `rx_valid`, `rx_stuff_err` and `flag_busy` are 0.
- R2: While `tx_region` is 1 and five equal bits have just been sent, the next strobe sends one bit opposite to that run. `tx_ready` is 0 during that bit time and the offered data is not consumed.
- R3: An inserted stuff bit counts as the first bit of the next run. Four further data bits equal to the stuff bit therefore cause another insertion.
- R4: A strobe with `tx_region` at 0 sends `tx_data` unchanged, inserts nothing and clears the transmit run count.
- R5: A strobe with no flag, no pending stuff bit and `tx_valid` at 0 sends recessive (1) and clears the transmit run count.
- R6: While `rx_region` is 1, a received bit that follows five equal bits and has the opposite value is dropped (no `rx_valid`). It counts as the first bit of a new run.
- R7: While `rx_region` is 1, a sixth equal bit in a row produces a one-cycle `rx_stuff_err` pulse and no `rx_valid`. Run counting then starts afresh with the next bit.
- R8: While `rx_region` is 0, every received bit is passed up with `rx_valid` and no stuff error is ever reported.
- R9: A flag request takes over the transmit line on the following strobes. It sends exactly six dominant (0) bits with no stuffing, holds `flag_busy` at 1 and `tx_ready` at 0, and then returns to normal operation with the run count cleared.
- R10: A flag request that arrives while a flag is pending or in progress is ignored and does not lengthen the flag.
- R11: With the automatic option enabled (default), a receive stuff error starts an error flag exactly as a request on `flag_req` would.
- R12: `rx_valid`, `rx_data` and `rx_stuff_err` become valid in the cycle after the strobe edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| flag_req | input | 1 | Request to send an active error flag |
| flag_busy | output | 1 | Error flag pending or being sent |
| tx_region | input | 1 | Stuffing applies to transmitted bits |
| tx_valid | input | 1 | Frame logic offers a bit |
| tx_data | input | 1 | Offered bit |
| tx_ready | output | 1 | Offered bit is taken on this strobe |
| tx_bit | output | 1 | Serial line bit, 0 dominant, 1 recessive |
| rx_region | input | 1 | Destuffing applies to received bits |
| rx_bit | input | 1 | Sampled bus bit |
| rx_valid | output | 1 | Destuffed bit available |
| rx_data | output | 1 | Destuffed bit |
| rx_stuff_err | output | 1 | Six equal bits seen inside the region |

## Verification
Directed runs cover four cases. Runs of exactly five equal bits followed by a change show that a stuff bit is inserted or dropped at the boundary and that the count restarts from the stuff bit. A sixth equal bit separates a dropped stuff bit from a stuff error and shows that the error starts the flag. Leaving the region in the middle of a run, or leaving an idle gap, shows that the count is cleared rather than carried over. Repeated flag requests during a flag show that the flag length stays fixed. A seeded random stream with runs biased long, toggling regions and occasional flag requests then mixes these cases in orders the directed runs do not reach.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_DATA  = 2'd1,
      SRC_STUFF = 2'd2,
      SRC_FLAG  = 2'd3
   } tx_src_e;

   localparam logic LVL_DOMINANT  = 1'b0;
   localparam logic LVL_RECESSIVE = 1'b1;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/cbs_run_track.sv
module cbs_run_track #(
   parameter int unsigned RUN_LEN = 5,
   localparam int unsigned RUN_W  = cbs_pkg::cnt_width(RUN_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic             clr,
   input  logic             bit_in,
   output logic [RUN_W-1:0] run_cnt,
   output logic             last_bit,
   output logic             run_full
);

   localparam logic [RUN_W-1:0] FULL_V = RUN_W'(RUN_LEN);
   localparam logic [RUN_W-1:0] ONE_V  = RUN_W'(1);

   logic same_run;

   assign same_run = (run_cnt != '0) && (bit_in == last_bit);
   assign run_full = (run_cnt == FULL_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt  <= '0;
         last_bit <= cbs_pkg::LVL_RECESSIVE;
      end else if (clr) begin
         run_cnt  <= '0;
      end else if (upd) begin
         last_bit <= bit_in;
         if (!same_run)
            run_cnt <= ONE_V;
         else if (!run_full)
            run_cnt <= run_cnt + ONE_V;
      end
   end

   a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= FULL_V);

   a_r3_new_run_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !clr && (bit_in != last_bit)) |=> (run_cnt == ONE_V));

endmodule

// File: rtl/cbs_flag_gen.sv
module cbs_flag_gen #(
   parameter int unsigned FLAG_LEN = 6,
   localparam int unsigned FW     = cbs_pkg::cnt_width(FLAG_LEN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic trig,
   output logic active
);

   localparam logic [FW-1:0] LAST_V = FW'(FLAG_LEN);

   logic          pend;
   logic [FW-1:0] cnt;
   logic [FW-1:0] nxt;

   assign active = pend || (cnt != '0);
   assign nxt    = (pend ? '0 : cnt) + FW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend <= 1'b0;
         cnt  <= '0;
      end else if (bit_tick && active) begin
         pend <= 1'b0;
         cnt  <= (nxt == LAST_V) ? '0 : nxt;
      end else if (trig && !active) begin
         pend <= 1'b1;
      end
   end

   a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < LAST_V);

   a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && (cnt != '0)) |=> (cnt == $past(cnt)));

   a_r10_no_pend_while_running: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> !pend);

endmodule

// File: rtl/cbs_tx_stuffer.sv
module cbs_tx_stuffer #(
   parameter int unsigned RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic region,
   input  logic flag_active,
   input  logic tx_valid,
   input  logic tx_data,
   output logic tx_ready,
   output logic tx_bit
);
   import cbs_pkg::*;

   localparam int unsigned RUN_W = cnt_width(RUN_LEN);

   tx_src_e          src;
   logic             stuff_due;
   logic             nxt_bit;
   logic             upd;
   logic             clr;
   logic [RUN_W-1:0] run_cnt;
   logic             last_bit;
   logic             run_full;

   assign stuff_due = region && run_full;

   always_comb begin
      if (flag_active)      src = SRC_FLAG;
      else if (stuff_due)   src = SRC_STUFF;
      else if (tx_valid)    src = SRC_DATA;
      else                  src = SRC_IDLE;
   end

   always_comb begin
      unique case (src)
         SRC_FLAG:  nxt_bit = LVL_DOMINANT;
         SRC_STUFF: nxt_bit = ~last_bit;
         SRC_DATA:  nxt_bit = tx_data;
         default:   nxt_bit = LVL_RECESSIVE;
      endcase
   end

   assign tx_ready = !flag_active && !stuff_due;
   assign upd      = bit_tick && ((src == SRC_STUFF) || ((src == SRC_DATA) && region));
   assign clr      = bit_tick && !upd;

   cbs_run_track #(.RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd),
      .clr      (clr),
      .bit_in   (nxt_bit),
      .run_cnt  (run_cnt),
      .last_bit (last_bit),
      .run_full (run_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_bit <= LVL_RECESSIVE;
      else if (bit_tick) tx_bit <= nxt_bit;
   end

   a_r2_stuff_opposite: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && (src == SRC_STUFF)) |=> (tx_bit != $past(last_bit)));

   a_r4_clear_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !region) |=> (run_cnt == '0));

   a_r5_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !flag_active && !stuff_due && !tx_valid) |=> (tx_bit == LVL_RECESSIVE));

endmodule

// File: rtl/cbs_rx_destuffer.sv
module cbs_rx_destuffer #(
   parameter int unsigned RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic region,
   input  logic rx_bit,
   output logic rx_valid,
   output logic rx_data,
   output logic rx_stuff_err
);
   import cbs_pkg::*;

   localparam int unsigned RUN_W = cnt_width(RUN_LEN);

   logic             at_stuff;
   logic             violation;
   logic             upd;
   logic             clr;
   logic [RUN_W-1:0] run_cnt;
   logic             last_bit;
   logic             run_full;

   assign at_stuff  = region && run_full;
   assign violation = at_stuff && (rx_bit == last_bit);
   assign upd       = bit_tick && region && !violation;
   assign clr       = bit_tick && (!region || violation);

   cbs_run_track #(.RUN_LEN(RUN_LEN)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd),
      .clr      (clr),
      .bit_in   (rx_bit),
      .run_cnt  (run_cnt),
      .last_bit (last_bit),
      .run_full (run_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_valid     <= 1'b0;
         rx_data      <= LVL_RECESSIVE;
         rx_stuff_err <= 1'b0;
      end else begin
         rx_valid     <= bit_tick && !at_stuff;
         rx_stuff_err <= bit_tick && violation;
         if (bit_tick) rx_data <= rx_bit;
      end
   end

   a_r12_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bit_tick));

   a_r7_err_only_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stuff_err |-> $past(region && (run_cnt == RUN_W'(RUN_LEN))));

   a_r7_err_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_stuff_err));

   a_r8_no_err_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && !region) |=> !rx_stuff_err);

endmodule

// File: rtl/can_stuff_unit.sv
module can_stuff_unit #(
   parameter int unsigned RUN_LEN   = 5,
   parameter int unsigned FLAG_LEN  = 6,
   parameter bit          AUTO_FLAG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic flag_req,
   output logic flag_busy,
   input  logic tx_region,
   input  logic tx_valid,
   input  logic tx_data,
   output logic tx_ready,
   output logic tx_bit,
   input  logic rx_region,
   input  logic rx_bit,
   output logic rx_valid,
   output logic rx_data,
   output logic rx_stuff_err
);

   logic flag_trig;

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
      if (FLAG_LEN <= RUN_LEN) begin : g_bad_flag
         $error("FLAG_LEN must exceed RUN_LEN so the flag breaks the stuffing rule");
      end
      if (AUTO_FLAG) begin : g_auto
         assign flag_trig = flag_req || rx_stuff_err;
      end else begin : g_manual
         assign flag_trig = flag_req;
      end
   endgenerate

   cbs_flag_gen #(.FLAG_LEN(FLAG_LEN)) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .trig     (flag_trig),
      .active   (flag_busy)
   );

   cbs_tx_stuffer #(.RUN_LEN(RUN_LEN)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .region      (tx_region),
      .flag_active (flag_busy),
      .tx_valid    (tx_valid),
      .tx_data     (tx_data),
      .tx_ready    (tx_ready),
      .tx_bit      (tx_bit)
   );

   cbs_rx_destuffer #(.RUN_LEN(RUN_LEN)) u_rx (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_tick     (bit_tick),
      .region       (rx_region),
      .rx_bit       (rx_bit),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_stuff_err (rx_stuff_err)
   );

   a_r9_flag_dominant: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && flag_busy) |=> (tx_bit == 1'b0));

   a_r9_flag_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
      flag_busy |-> !tx_ready);

endmodule

// File: tb/can_stuff_unit_tb.sv
`timescale 1ns/1ps
module can_stuff_unit_tb;

   localparam int RUN  = 5;
   localparam int FLAG = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic flag_req = 1'b0;
   logic tx_region = 1'b0;
   logic tx_valid = 1'b0;
   logic tx_data = 1'b0;
   logic rx_region = 1'b0;
   logic rx_bit = 1'b1;
   logic flag_busy, tx_ready, tx_bit, rx_valid, rx_data, rx_stuff_err;

   int checks = 0;
   int failures = 0;

   // reference model state
   int m_trun = 0;
   int m_tlast = 1;
   int m_rrun = 0;
   int m_rlast = 1;
   int m_fcnt = 0;
   bit m_fpend = 1'b0;

   always #2.5 clk = ~clk;

   can_stuff_unit u_dut (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .flag_req(flag_req),
      .flag_busy(flag_busy), .tx_region(tx_region), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .tx_bit(tx_bit),
      .rx_region(rx_region), .rx_bit(rx_bit), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_stuff_err(rx_stuff_err)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic bit m_active();
      return m_fpend || (m_fcnt != 0);
   endfunction

   task automatic pulse_flag_req();
      @(negedge clk);
      flag_req = 1'b1;
      if (!m_active()) m_fpend = 1'b1;
      @(negedge clk);
      flag_req = 1'b0;
   endtask

   // one bit time: drive at negedge, strobe, check after the edge
   task automatic do_tick(input bit v, input bit d, input bit tr,
                          input bit rb, input bit rr, input string tag_in);
      bit exp_ready, exp_tx, exp_rv, exp_re, act;
      int nxt;
      string ttag, rtag;
      @(negedge clk);
      tx_valid = v; tx_data = d; tx_region = tr; rx_bit = rb; rx_region = rr;
      #1;
      act = m_active();
      exp_ready = !act && !(tr && (m_trun == RUN));
      chk(tx_ready === exp_ready, (tag_in != "") ? tag_in : "R2", "tx_ready", tx_ready, exp_ready);
      chk(flag_busy === act, (tag_in != "") ? tag_in : "R9", "flag_busy", flag_busy, act);
      bit_tick = 1'b1;
      // transmit model
      if (act) begin
         exp_tx = 1'b0; ttag = "R9";
         nxt = (m_fpend ? 0 : m_fcnt) + 1;
         m_fcnt = (nxt == FLAG) ? 0 : nxt;
         m_fpend = 1'b0;
         m_trun = 0;
      end else if (tr && (m_trun == RUN)) begin
         exp_tx = !m_tlast[0]; ttag = "R2";
         m_tlast = exp_tx; m_trun = 1;
      end else if (v) begin
         exp_tx = d;
         if (tr) begin
            ttag = "R3";
            m_trun = (m_trun != 0 && d == m_tlast[0]) ? m_trun + 1 : 1;
            m_tlast = d;
         end else begin
            ttag = "R4"; m_trun = 0;
         end
      end else begin
         exp_tx = 1'b1; ttag = "R5"; m_trun = 0;
      end
      // receive model
      exp_rv = 1'b1; exp_re = 1'b0;
      if (!rr) begin
         rtag = "R8"; m_rrun = 0;
      end else if (m_rrun == RUN) begin
         exp_rv = 1'b0;
         if (rb != m_rlast[0]) begin
            rtag = "R6"; m_rrun = 1; m_rlast = rb;
         end else begin
            rtag = "R7"; exp_re = 1'b1; m_rrun = 0;
         end
      end else begin
         rtag = "R12";
         m_rrun = (m_rrun != 0 && rb == m_rlast[0]) ? m_rrun + 1 : 1;
         m_rlast = rb;
      end
      if (exp_re && !m_active()) m_fpend = 1'b1; // R11 automatic flag
      if (tag_in != "") begin ttag = tag_in; rtag = tag_in; end
      @(negedge clk);
      bit_tick = 1'b0;
      chk(tx_bit === exp_tx, ttag, "tx_bit", tx_bit, exp_tx);
      chk(rx_valid === exp_rv, rtag, "rx_valid", rx_valid, exp_rv);
      chk(rx_stuff_err === exp_re, rtag, "rx_stuff_err", rx_stuff_err, exp_re);
      if (exp_rv) chk(rx_data === rb, rtag, "rx_data", rx_data, rb);
      @(negedge clk);
      chk(!rx_valid && !rx_stuff_err, "R12", "rx pulse width", rx_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int seed_init;
      bit cur_t, cur_r, tr, rr;
      seed_init = $urandom(32'd7331);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(tx_bit === 1'b1, "R1", "tx_bit", tx_bit, 1);
      chk(tx_ready === 1'b1, "R1", "tx_ready", tx_ready, 1);
      chk(!rx_valid && !rx_stuff_err, "R1", "rx outputs", rx_valid, 0);
      chk(flag_busy === 1'b0, "R1", "flag_busy", flag_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: five zeros then a stuffed one
      repeat (5) do_tick(1, 0, 1, 1, 0, "");
      do_tick(1, 0, 1, 1, 0, "R2");
      // R3: stuff bit begins the next run
      repeat (4) do_tick(1, 1, 1, 1, 0, "");
      do_tick(1, 1, 1, 1, 0, "R3");
      do_tick(1, 1, 1, 1, 0, "");
      // R4: outside the region nothing is stuffed, and the run restarts after
      repeat (3) do_tick(1, 0, 1, 1, 0, "");
      repeat (4) do_tick(1, 0, 0, 1, 0, "R4");
      repeat (4) do_tick(1, 0, 1, 1, 0, "R4");
      do_tick(1, 1, 1, 1, 0, "");
      // R5: idle bit clears the run
      repeat (3) do_tick(1, 0, 1, 1, 0, "");
      do_tick(0, 0, 1, 1, 0, "R5");
      repeat (4) do_tick(1, 0, 1, 1, 0, "R5");
      do_tick(1, 1, 1, 1, 0, "");
      // R6: receive drops stuff bits and restarts the run from them
      repeat (5) do_tick(0, 0, 0, 1, 1, "");
      do_tick(0, 0, 0, 0, 1, "R6");
      repeat (4) do_tick(0, 0, 0, 0, 1, "");
      do_tick(0, 0, 0, 1, 1, "R6");
      // R7 + R11: sixth equal bit is an error and starts a flag
      repeat (4) do_tick(0, 0, 0, 1, 1, "");
      do_tick(0, 0, 0, 1, 1, "R7");
      chk(flag_busy === 1'b1, "R11", "flag after stuff error", flag_busy, 1);
      repeat (FLAG) do_tick(1, 1, 0, 0, 0, "R11");
      do_tick(1, 1, 0, 1, 0, "R9");
      // R8: receive outside the region passes everything
      repeat (8) do_tick(0, 0, 0, 0, 0, "R8");
      // R9 + R10: flag length fixed despite repeated requests
      pulse_flag_req();
      do_tick(1, 1, 1, 1, 0, "R9");
      pulse_flag_req();
      repeat (3) do_tick(1, 1, 1, 1, 0, "R10");
      pulse_flag_req();
      repeat (2) do_tick(1, 1, 1, 1, 0, "R10");
      do_tick(1, 1, 1, 1, 0, "R10");
      chk(flag_busy === 1'b0, "R10", "flag ended", flag_busy, 0);

      // random mix
      cur_t = 1'b0; cur_r = 1'b0; tr = 1'b1; rr = 1'b1;
      for (int i = 0; i < 3000; i++) begin
         if ($urandom_range(3, 0) == 0) cur_t = ~cur_t;
         if ($urandom_range(3, 0) == 0) cur_r = ~cur_r;
         if ($urandom_range(39, 0) == 0) tr = ~tr;
         if ($urandom_range(39, 0) == 0) rr = ~rr;
         if ($urandom_range(79, 0) == 0) pulse_flag_req();
         do_tick($urandom_range(9, 0) != 0, cur_t, tr, cur_r, rr, "");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule